// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises a processor that must service it at a steady pace. The processor signals that it is alive by driving a falling edge on a kick line. Every accepted kick opens a new timing window. The next kick is only legal after a minimum number of clock cycles and no later than a maximum number of cycles. A kick that comes too soon is a fault, and so is the absence of a kick by the maximum. Either fault produces an active-low pulse of fixed width, which can feed a non-maskable interrupt or a reset line.

The two fault kinds recover differently. After a late fault, the next window is timed from the end of the pulse. After an early fault, the block waits for the first kick edge that follows the end of the pulse, and that kick starts the next window. Software can test the supervisor on purpose by kicking too fast or by not kicking at all, and then watching for the pulse.

The kick input may be asynchronous. It is resynchronised before the edge is detected. All intervals and the pulse width are parameters counted in clock cycles.

Top module: `window_watchdog`

## Requirements
- R1: Only a high-to-low transition of `kick_raw` counts as a kick. A low level that is held, or a rising edge, starts nothing. The input passes through two synchroniser flops, so a low level first sampled at rising edge k is taken as a kick at rising edge k+2.
- R2: A kick taken fewer than `FAST_TICKS` cycles after the window reference edge is an early fault.
- R3: If no kick is taken within `SLOW_TICKS` cycles of the reference edge, a late fault starts at reference + `SLOW_TICKS`.
- R4: A kick taken between `FAST_TICKS` and `SLOW_TICKS` cycles after the reference, both ends included, raises no fault and becomes the new reference.
- R5: On a fault, `fault_n` goes low immediately after the edge that takes the fault. It stays low for exactly `PULSE_TICKS` cycles.
- R6: After an early fault, kicks taken while the pulse is active are ignored. The first kick taken after the pulse ends is accepted whatever its timing and becomes the new reference. If no such kick comes within `SLOW_TICKS` cycles of the pulse end, a late fault starts.
- R7: After a late fault, the edge that ends the pulse becomes the reference of a fresh window.
- R8: While `rst` is high, `fault_n` is high, even in the middle of a pulse. The last edge at which `rst` is high acts as the reference for the first window.
- R9: The parameters must satisfy `FAST_TICKS` < `SLOW_TICKS` and `PULSE_TICKS` >= 1. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| kick_raw | input | 1 | Raw kick input from the processor; a falling edge is a kick |
| fault_n | output | 1 | Fault pulse, active low |

## Verification
The bench builds the block with `FAST_TICKS`=8, `SLOW_TICKS`=20 and `PULSE_TICKS`=4. With these values a complete window, a whole pulse and the recovery after it all take only a few dozen cycles. That makes it cheap to place kicks exactly on both window limits, one cycle inside the early zone, inside an active pulse, and shortly after a pulse ends. The chains that follow each fault kind (late then early, early then late by silence) can then be run back to back with exact edge positions checked.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int FAST_TICKS  = 39000,
  parameter int SLOW_TICKS  = 47000,
  parameter int PULSE_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_raw,
  output logic fault_n
);

  localparam int MAXC = (SLOW_TICKS > PULSE_TICKS) ? SLOW_TICKS : PULSE_TICKS;
  localparam int CW   = $clog2(MAXC + 1) + 1;
  localparam logic [CW-1:0] FAST_C  = CW'(FAST_TICKS);
  localparam logic [CW-1:0] SLOW_C  = CW'(SLOW_TICKS);
  localparam logic [CW-1:0] PULSE_C = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] ONE     = CW'(1);

  localparam logic [1:0] S_RUN   = 2'd0;
  localparam logic [1:0] S_PULSE = 2'd1;
  localparam logic [1:0] S_WAIT  = 2'd2;

  // R9 parameter sanity
  if (!(FAST_TICKS < SLOW_TICKS) || PULSE_TICKS < 1 || FAST_TICKS < 1) begin : g_bad_params
    $error("window_watchdog: need 1 <= FAST_TICKS < SLOW_TICKS and PULSE_TICKS >= 1");
  end

  logic [2:0]    ksh;
  logic          fall;
  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          early_q;

  always_ff @(posedge clk) begin
    if (rst) ksh <= 3'b111;
    else     ksh <= {ksh[1:0], kick_raw};
  end

  assign fall    = ksh[2] & ~ksh[1];
  assign fault_n = (st != S_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_RUN;
      cnt     <= ONE;
      early_q <= 1'b0;
    end else begin
      case (st)
        S_RUN: begin
          if (fall) begin
            if (cnt < FAST_C) begin
              st      <= S_PULSE;
              early_q <= 1'b1;
            end
            cnt <= ONE;
          end else if (cnt >= SLOW_C) begin
            st      <= S_PULSE;
            early_q <= 1'b0;
            cnt     <= ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        S_PULSE: begin
          if (cnt >= PULSE_C) begin
            st  <= early_q ? S_WAIT : S_RUN;
            cnt <= ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        S_WAIT: begin
          if (fall) begin
            st  <= S_RUN;
            cnt <= ONE;
          end else if (cnt >= SLOW_C) begin
            st      <= S_PULSE;
            early_q <= 1'b0;
            cnt     <= ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: begin
          st  <= S_RUN;
          cnt <= ONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/window_watchdog_props.sv
module window_watchdog_props #(
  parameter int FAST_TICKS  = 39000,
  parameter int SLOW_TICKS  = 47000,
  parameter int PULSE_TICKS = 1000,
  parameter int CW          = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          fault_n,
  input logic          fall,
  input logic [1:0]    st,
  input logic [CW-1:0] cnt
);

  int lowcnt;
  always_ff @(posedge clk) begin
    if (rst)          lowcnt <= 0;
    else if (fault_n) lowcnt <= 0;
    else              lowcnt <= lowcnt + 1;
  end

  a_r2_early_fault: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && fall && int'(cnt) < FAST_TICKS) |=> !fault_n);

  a_r3_late_fault: assert property (@(posedge clk) disable iff (rst)
    (st != 2'd1 && !fall && int'(cnt) >= SLOW_TICKS) |=> !fault_n);

  a_r4_window_ok: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && fall && int'(cnt) >= FAST_TICKS) |=> fault_n);

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    ($rose(fault_n) && !$past(rst)) |-> lowcnt == PULSE_TICKS);

  a_r6_hold_pulse: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && int'(cnt) < PULSE_TICKS) |=> !fault_n);

  a_r8_reset_high: assert property (@(posedge clk)
    rst |=> fault_n);

endmodule

bind window_watchdog window_watchdog_props #(
  .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS),
  .PULSE_TICKS(PULSE_TICKS), .CW(CW)
) u_props (
  .clk(clk), .rst(rst), .fault_n(fault_n),
  .fall(fall), .st(st), .cnt(cnt)
);

// File: tb/test_window_watchdog.sv
module test_window_watchdog;
  localparam int FAST  = 8;
  localparam int SLOW  = 20;
  localparam int PULSE = 4;
  localparam int NV    = 9;
  // kind: 0 in-window kick, 1 early kick, 2 recovery kick after early pulse
  localparam int TBL_D [NV] = '{8, 20, 12, 7, 9, 10, 5, 6, 15};
  localparam int TBL_K [NV] = '{0, 0,  0,  1, 2, 0,  1, 2, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_raw = 1'b1;
  logic fault_n;

  window_watchdog #(.FAST_TICKS(FAST), .SLOW_TICKS(SLOW), .PULSE_TICKS(PULSE)) i_window_watchdog (
    .clk(clk), .rst(rst), .kick_raw(kick_raw), .fault_n(fault_n));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int edge_cnt = 0;
  int starts = 0, last_start = -1, last_width = -1;
  bit mon_prev = 1'b1;
  int refe, acted, exp_starts, a_e, e_e;
  bit done = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  always @(posedge clk) begin
    #2;
    if (!fault_n && mon_prev) begin starts++; last_start = edge_cnt; end
    if (fault_n && !mon_prev) last_width = edge_cnt - last_start;
    mon_prev = fault_n;
  end

  always @(posedge clk) begin
    if (edge_cnt > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", edge_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_to(input int e);
    while (edge_cnt < e) @(negedge clk);
  endtask

  // kick taken at edge refe+d: low sampled at X+1, taken at X+3
  task automatic kick(input int base, input int d, input bit hold);
    int x = base + d - 3;
    wait_to(x);
    kick_raw = 1'b0;
    if (!hold) begin
      wait_to(x + 2);
      kick_raw = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    refe = edge_cnt;
    chk(fault_n == 1'b1, "R8 reset state", fault_n, 1);
    wait_to(refe + 3);
    chk(fault_n == 1'b1, "R8 after release", fault_n, 1);

    exp_starts = 0;
    for (int i = 0; i < NV; i++) begin
      kick(refe, TBL_D[i], 1'b0);
      acted = refe + TBL_D[i];
      wait_to(acted + 1);
      if (TBL_K[i] == 1) begin
        exp_starts++;
        chk(starts == exp_starts, "R2 early fault count", starts, exp_starts);
        chk(last_start == acted, "R2 R5 early fault edge", last_start, acted);
      end else if (TBL_K[i] == 2) begin
        chk(starts == exp_starts, "R6 recovery no fault", starts, exp_starts);
        chk(last_width == PULSE, "R5 pulse width", last_width, PULSE);
      end else begin
        chk(starts == exp_starts, "R4 window kick no fault", starts, exp_starts);
        chk(fault_n == 1'b1, "R4 output high", fault_n, 1);
      end
      refe = acted;
    end

    // R3 late fault, then R7 window from pulse end
    wait_to(refe + SLOW + 1);
    chk(last_start == refe + SLOW, "R3 late fault edge", last_start, refe + SLOW);
    e_e = refe + SLOW + PULSE;
    wait_to(e_e + 1);
    chk(last_width == PULSE, "R5 late pulse width", last_width, PULSE);
    kick(e_e, FAST - 1, 1'b0);
    wait_to(e_e + FAST);
    chk(last_start == e_e + FAST - 1, "R7 early after late pulse", last_start, e_e + FAST - 1);
    a_e = e_e + FAST - 1;
    kick(a_e, PULSE + 2, 1'b0);
    refe = a_e + PULSE + 2;
    exp_starts = starts;

    // R1 held low gives one kick only; rising edge is no kick
    kick(refe, 10, 1'b1);
    refe = refe + 10;
    wait_to(refe + SLOW - 1);
    chk(starts == exp_starts, "R1 held low no early fault", starts, exp_starts);
    wait_to(refe + SLOW + 1);
    chk(last_start == refe + SLOW, "R1 held low late fault", last_start, refe + SLOW);
    wait_to(refe + SLOW + 2);
    kick_raw = 1'b1;
    e_e = refe + SLOW + PULSE;
    wait_to(e_e + SLOW + 1);
    chk(last_start == e_e + SLOW, "R1 R7 rising edge ignored", last_start, e_e + SLOW);

    // R6 kick inside early pulse ignored, silence then late
    e_e = e_e + SLOW + PULSE;
    kick(e_e, 5, 1'b0);
    a_e = e_e + 5;
    kick(a_e, PULSE, 1'b0);
    wait_to(a_e + PULSE + 1);
    exp_starts = starts;
    wait_to(a_e + PULSE + SLOW + 1);
    chk(last_start == a_e + PULSE + SLOW, "R6 late after early wait", last_start, a_e + PULSE + SLOW);
    chk(starts == exp_starts + 1, "R6 kick in pulse ignored", starts, exp_starts + 1);

    // R8 reset during pulse
    rst = 1'b1;
    @(negedge clk);
    chk(fault_n == 1'b1, "R8 reset mid pulse", fault_n, 1);
    rst = 1'b0;
    refe = edge_cnt;
    wait_to(refe + SLOW - 1);
    chk(fault_n == 1'b1, "R8 first window from release", fault_n, 1);
    wait_to(refe + SLOW + 1);
    chk(last_start == refe + SLOW, "R8 R3 late from release", last_start, refe + SLOW);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule